// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Sender

This block holds the command that software uses to send a message from one processor to others. It has two memory-mapped 32-bit words. The high word holds the destination identifier. The low word holds the vector, the message kind, the signalling bits and a destination shorthand. A write to the low word while no message is in flight launches a message.

The launched message is captured into an output register and offered on a valid/ready port. The port carries the resolved destination, delivery mode, vector, assert/de-assert level, trigger type and shorthand. Until the port accepts the message, a read-only delivery-status bit in the low word reads as 1. Software polls that bit and waits for it to clear before it issues the next command.

The shorthand field can replace the explicit destination with the sender itself or with a broadcast group. A startup message uses the vector as a 4 KiB page number, which is the start address shifted right by 12.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After reset, `msg_valid` is 0, and both the low word (byte offset 0x300) and the high word (byte offset 0x310) read as 0.
- R2: A write to offset 0x310 stores bits 31:24 as the destination identifier. A read of 0x310 returns that identifier in bits 31:24 and zeros in every other bit.
- R3: A write to offset 0x300 while idle sets `msg_valid` on the next cycle. From that cycle, delivery status (bit 12 of the low word) reads 1.
- R4: The low word keeps the vector in bits 7:0, the delivery mode in bits 10:8 (5 = INIT, 6 = startup), the level in bit 14 (1 = assert), the trigger in bit 15 (1 = level-triggered) and the shorthand in bits 19:18. These fields appear on the matching message outputs and read back at the same positions. All other bits read as 0, apart from bit 12.
- R5: The message destination depends on the shorthand. Shorthand 00 uses the stored destination identifier. Shorthand 01 uses the sender's own identifier (parameter `SELF_ID`). Shorthand 10 (all including self) and shorthand 11 (all except self) both use the all-ones identifier 0xFF.
- R6: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and every message field stays unchanged.
- R7: On the cycle after a clock edge where `msg_valid` and `msg_ready` are both 1, `msg_valid` is 0 and delivery status reads 0.
- R8: A write to offset 0x300 while delivery status is 1 is ignored. The stored low word and the message outputs keep the pending command.
- R9: A write to any offset other than 0x300 or 0x310 changes neither word and launches no message.
- R10: A write to offset 0x310 while a message is in flight updates the stored identifier. It does not change the destination of the in-flight message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`; combinational |
| msg_valid | output | 1 | A message is offered on the output port |
| msg_ready | input | 1 | The output port accepts the offered message |
| msg_dest | output | 8 | Resolved destination identifier |
| msg_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector or startup page number |
| msg_level | output | 1 | 1 = assert, 0 = de-assert |
| msg_trigger | output | 1 | 1 = level-triggered, 0 = edge-triggered |
| msg_shorthand | output | 2 | Destination shorthand code |

## Verification
The assertions check four rules on every cycle. An idle low-word write always launches a message. An offered message holds steady until it is accepted. The status clears right after the handshake. A low-word write while busy leaves the stored command untouched. They also check capture of the high word and resolution to the sender's own identifier. The bench scenarios are the only place that shows the full field layout on readback, the broadcast resolution to 0xFF, and writes to unmapped offsets doing nothing. They also show that a mid-flight change of the destination word leaves the launched message alone.

// File: rtl/ipi_pkg.sv
// Package: shared types and field positions for the inter-processor
// interrupt command sender. Assumes a 32-bit register word and an
// 8-bit processor identifier.
package ipi_pkg;

    localparam int WORD_W = 32;
    localparam int ID_W   = 8;
    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;

    // Bit positions inside the low command word.
    localparam int VEC_LSB    = 0;
    localparam int MODE_LSB   = 8;
    localparam int STATUS_BIT = 12;
    localparam int LEVEL_BIT  = 14;
    localparam int TRIG_BIT   = 15;
    localparam int SH_LSB     = 18;
    localparam int DEST_LSB   = 24;

    localparam logic [MODE_W-1:0] MODE_INIT    = 3'd5;
    localparam logic [MODE_W-1:0] MODE_STARTUP = 3'd6;

    typedef enum logic [1:0] {
        SH_DEST   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } shorthand_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              level;
        logic              trigger;
        shorthand_e        shorthand;
    } low_cmd_t;

    typedef struct packed {
        logic [ID_W-1:0]   dest;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
        logic              level;
        logic              trigger;
        shorthand_e        shorthand;
    } ipi_msg_t;

endpackage

// File: rtl/ipi_cmd_regs.sv
// Module: ipi_cmd_regs
// Stores the destination word and the low command word. The low word is
// written only when the launch controller accepts the write, so writes
// made while a message is pending never reach it. Assumes the caller has
// already decoded the offsets.
module ipi_cmd_regs
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo_accept,
    input  logic [WORD_W-1:0] wdata,
    output logic [ID_W-1:0]   hi_dest,
    output low_cmd_t          lo_cmd
);

    // Capture the destination identifier on a high-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_dest <= '0;
        end else if (wr_hi) begin
            hi_dest <= wdata[DEST_LSB +: ID_W];
        end
    end

    // Capture the command fields on an accepted low-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cmd <= '0;
        end else if (wr_lo_accept) begin
            lo_cmd.vector    <= wdata[VEC_LSB +: VEC_W];
            lo_cmd.mode      <= wdata[MODE_LSB +: MODE_W];
            lo_cmd.level     <= wdata[LEVEL_BIT];
            lo_cmd.trigger   <= wdata[TRIG_BIT];
            lo_cmd.shorthand <= shorthand_e'(wdata[SH_LSB +: 2]);
        end
    end

    // R2: the high word captures the identifier bits of the write data.
    assert_hi_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> hi_dest == $past(wdata[DEST_LSB +: ID_W]));

endmodule

// File: rtl/ipi_dest_resolve.sv
// Module: ipi_dest_resolve
// Turns the shorthand code and the stored identifier into the destination
// the message carries. Purely combinational. Assumes that the all-ones
// identifier means "every processor".
module ipi_dest_resolve
    import ipi_pkg::*;
#(
    parameter logic [ID_W-1:0] SELF_ID = 8'h00
) (
    input  shorthand_e      shorthand,
    input  logic [ID_W-1:0] hi_dest,
    output logic [ID_W-1:0] dest
);

    localparam logic [ID_W-1:0] ALL_ID = {ID_W{1'b1}};

    // Select the destination: explicit, self, or the broadcast identifier.
    always_comb begin
        unique case (shorthand)
            SH_DEST:   dest = hi_dest;
            SH_SELF:   dest = SELF_ID;
            default:   dest = ALL_ID;
        endcase
    end

endmodule

// File: rtl/ipi_launch_ctrl.sv
// Module: ipi_launch_ctrl
// Tracks delivery status and holds the launched message on a valid/ready
// port. A low-word write is accepted only while idle. Status is set on the
// next cycle and clears on the cycle after the handshake. Assumes the
// message fields it is given are valid in the cycle of the write.
module ipi_launch_ctrl
    import ipi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_lo,
    input  ipi_msg_t next_msg,
    input  logic     msg_ready,
    output logic     accept,
    output logic     busy,
    output ipi_msg_t msg
);

    // Accept a launch only when nothing is in flight.
    always_comb accept = wr_lo && !busy;

    // Delivery status: set on launch, cleared after the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
        end else if (busy && msg_ready) begin
            busy <= 1'b0;
        end
    end

    // Snapshot the message at launch so later register writes cannot alter it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg <= '0;
        end else if (accept) begin
            msg <= next_msg;
        end
    end

    // R3: an idle low-word write launches on the next cycle.
    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !busy) |=> busy);

    // R6: an offered message holds steady until accepted.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !msg_ready) |=> (busy && $stable(msg)));

    // R7: the status drops right after the handshake.
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && msg_ready) |=> !busy);

endmodule

// File: rtl/ipi_cmd_sender.sv
// Module: ipi_cmd_sender (top)
// Register pair for sending inter-processor messages. It decodes the
// byte offsets, stores the command words, resolves the destination and
// drives the valid/ready message port. Reads are combinational. Assumes
// single-cycle write strobes on a word-aligned register bus.
module ipi_cmd_sender
    import ipi_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] LO_OFS = 12'h300,
    parameter logic [ADDR_W-1:0] HI_OFS = 12'h310,
    parameter logic [7:0]      SELF_ID  = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_dest,
    output logic [2:0]        msg_mode,
    output logic [7:0]        msg_vector,
    output logic              msg_level,
    output logic              msg_trigger,
    output logic [1:0]        msg_shorthand
);

    logic            sel_lo;
    logic            sel_hi;
    logic            wr_lo;
    logic            wr_hi;
    logic            accept;
    logic            busy;
    logic [ID_W-1:0] hi_dest;
    logic [ID_W-1:0] next_dest;
    low_cmd_t        lo_cmd;
    low_cmd_t        next_lo;
    ipi_msg_t        next_msg;
    ipi_msg_t        cur_msg;

    // Decode the register offsets.
    always_comb begin
        sel_lo = (bus_addr == LO_OFS);
        sel_hi = (bus_addr == HI_OFS);
        wr_lo  = bus_wr && sel_lo;
        wr_hi  = bus_wr && sel_hi;
    end

    ipi_cmd_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hi        (wr_hi),
        .wr_lo_accept (accept),
        .wdata        (bus_wdata),
        .hi_dest      (hi_dest),
        .lo_cmd       (lo_cmd)
    );

    // Unpack the incoming low word for the message built at launch.
    always_comb begin
        next_lo.vector    = bus_wdata[VEC_LSB +: VEC_W];
        next_lo.mode      = bus_wdata[MODE_LSB +: MODE_W];
        next_lo.level     = bus_wdata[LEVEL_BIT];
        next_lo.trigger   = bus_wdata[TRIG_BIT];
        next_lo.shorthand = shorthand_e'(bus_wdata[SH_LSB +: 2]);
    end

    ipi_dest_resolve #(.SELF_ID(SELF_ID)) u_resolve (
        .shorthand (next_lo.shorthand),
        .hi_dest   (hi_dest),
        .dest      (next_dest)
    );

    // Assemble the message that a launch would capture.
    always_comb begin
        next_msg.dest      = next_dest;
        next_msg.mode      = next_lo.mode;
        next_msg.vector    = next_lo.vector;
        next_msg.level     = next_lo.level;
        next_msg.trigger   = next_lo.trigger;
        next_msg.shorthand = next_lo.shorthand;
    end

    ipi_launch_ctrl u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .next_msg  (next_msg),
        .msg_ready (msg_ready),
        .accept    (accept),
        .busy      (busy),
        .msg       (cur_msg)
    );

    // Drive the message port from the launched snapshot.
    always_comb begin
        msg_valid     = busy;
        msg_dest      = cur_msg.dest;
        msg_mode      = cur_msg.mode;
        msg_vector    = cur_msg.vector;
        msg_level     = cur_msg.level;
        msg_trigger   = cur_msg.trigger;
        msg_shorthand = cur_msg.shorthand;
    end

    // Return register contents for the addressed word; zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (sel_lo) begin
            bus_rdata[VEC_LSB +: VEC_W]   = lo_cmd.vector;
            bus_rdata[MODE_LSB +: MODE_W] = lo_cmd.mode;
            bus_rdata[STATUS_BIT]         = busy;
            bus_rdata[LEVEL_BIT]          = lo_cmd.level;
            bus_rdata[TRIG_BIT]           = lo_cmd.trigger;
            bus_rdata[SH_LSB +: 2]        = lo_cmd.shorthand;
        end else if (sel_hi) begin
            bus_rdata[DEST_LSB +: ID_W]   = hi_dest;
        end
    end

    // R5: a self-addressed message carries the sender's own identifier.
    assert_self_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == SH_SELF) |-> msg_dest == SELF_ID);

    // R8: a low-word write while busy leaves the stored command unchanged.
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && msg_valid) |=> lo_cmd == $past(lo_cmd));

endmodule

// File: tb/sim_ipi_cmd_sender.sv
// Bench: mixes directed corner cases with seeded random commands. Every
// expected value comes from the bench's own functions.
module sim_ipi_cmd_sender;
    localparam logic [11:0] LO = 12'h300;
    localparam logic [11:0] HI = 12'h310;
    localparam logic [7:0]  SELF = 8'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_dest;
    logic [2:0]  msg_mode;
    logic [7:0]  msg_vector;
    logic        msg_level;
    logic        msg_trigger;
    logic [1:0]  msg_shorthand;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ipi_cmd_sender #(.SELF_ID(SELF)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_mode(msg_mode),
        .msg_vector(msg_vector), .msg_level(msg_level),
        .msg_trigger(msg_trigger), .msg_shorthand(msg_shorthand)
    );

    function automatic logic [7:0] exp_dest(logic [1:0] sh, logic [7:0] hid);
        case (sh)
            2'b00:   return hid;
            2'b01:   return SELF;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [31:0] lo_view(logic [31:0] w, logic st);
        return (w & 32'h000C_C7FF) | (32'(st) << 12);
    endfunction

    function automatic logic [31:0] msg_word();
        return {msg_dest, 1'b0, msg_mode, msg_vector, 2'b0, msg_level,
                msg_trigger, 6'b0, msg_shorthand};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic release_msg();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        #1;
    endtask

    // Check the message port against a command word and destination id.
    task automatic check_msg(string req, logic [31:0] w, logic [7:0] hid);
        check({req, " valid"}, 32'(msg_valid), 32'd1);
        check({req, " dest"}, 32'(msg_dest), 32'(exp_dest(w[19:18], hid)));
        check({req, " mode"}, 32'(msg_mode), 32'(w[10:8]));
        check({req, " vector"}, 32'(msg_vector), 32'(w[7:0]));
        check({req, " level"}, 32'(msg_level), 32'(w[14]));
        check({req, " trigger"}, 32'(msg_trigger), 32'(w[15]));
        check({req, " shorthand"}, 32'(msg_shorthand), 32'(w[19:18]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] cmd;
        logic [31:0] snap;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 valid", 32'(msg_valid), 32'd0);
        rd(LO, r); check("R1 low", r, 32'd0);
        rd(HI, r); check("R1 high", r, 32'd0);

        // R2: only bits 31:24 of the high word are kept
        wr(HI, 32'hA5FF_FFFF);
        rd(HI, r); check("R2 high readback", r, 32'hA500_0000);

        // R3/R4/R5: INIT broadcast, level-triggered de-assert
        cmd = (32'd2 << 18) | (32'd1 << 15) | (32'd5 << 8) | 32'h0000_1000;
        wr(LO, cmd);
        check_msg("R4 R5 init bcast", cmd, 8'hA5);
        rd(LO, r); check("R3 status set", r, lo_view(cmd, 1'b1));

        // R6: hold while not ready
        snap = msg_word();
        repeat (3) @(negedge clk);
        #1;
        check("R6 valid held", 32'(msg_valid), 32'd1);
        check("R6 fields stable", msg_word(), snap);

        // R8: low write while busy is ignored
        wr(LO, 32'h0007_C6FF);
        rd(LO, r); check("R8 low kept", r, lo_view(cmd, 1'b1));
        check("R8 msg kept", msg_word(), snap);

        // R10: a high write mid-flight does not alter the message
        wr(HI, 32'h1100_0000);
        rd(HI, r); check("R10 high updated", r, 32'h1100_0000);
        check("R10 msg dest kept", 32'(msg_dest), 32'hFF);

        // R7: release
        release_msg();
        check("R7 valid cleared", 32'(msg_valid), 32'd0);
        rd(LO, r); check("R7 status clear", r, lo_view(cmd, 1'b0));

        // R4/R5: startup to the explicit id, vector is the page number
        cmd = (32'h0009_A000 >> 12) | (32'd6 << 8) | (32'd1 << 14);
        wr(LO, cmd);
        check_msg("R4 R5 startup", cmd, 8'h11);
        check("R4 startup page", 32'(msg_vector), 32'h9A);
        release_msg();

        // R5: self and all-but-self
        cmd = (32'd1 << 18) | 32'h0000_0042;
        wr(LO, cmd);
        check_msg("R5 self", cmd, 8'h11);
        release_msg();
        cmd = (32'd3 << 18) | 32'h0000_0043;
        wr(LO, cmd);
        check_msg("R5 others", cmd, 8'h11);
        release_msg();

        // R9: unmapped offset writes do nothing
        wr(12'h304, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        check("R9 no launch", 32'(msg_valid), 32'd0);
        rd(LO, r); check("R9 low kept", r, lo_view(cmd, 1'b0));
        rd(HI, r); check("R9 high kept", r, 32'h1100_0000);

        // Random commands with random ready latency
        for (int i = 0; i < 40; i++) begin
            logic [7:0]  hid;
            int          lat;
            hid = 8'($urandom);
            cmd = $urandom;
            lat = $urandom_range(0, 3);
            wr(HI, {hid, 24'($urandom)});
            wr(LO, cmd);
            check_msg("R4 R5 random", cmd, hid);
            rd(LO, r); check("R3 random status", r, lo_view(cmd, 1'b1));
            snap = msg_word();
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                #1;
                check("R6 random hold", msg_word(), snap);
            end
            release_msg();
            check("R7 random clear", 32'(msg_valid), 32'd0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule